// File: doc/BRIEF.md
# Control Endpoint Request Status Handshake

This block sits between firmware and the engine that runs a USB control endpoint. When a SETUP packet arrives, the endpoint engine presents the request type and request code. Three kinds of request are left to firmware: class-specific requests, vendor-specific requests and SYNCH_FRAME. For those, the block opens a pending request and answers the status stage with NAK until firmware reports an outcome. Firmware reports it by writing two command bits in a single register write. "done" alone means success, and the block answers ACK with a zero-length status packet. "done" together with "fail" means the request failed, and the block answers STALL. Any write with "done" clear leaves the request busy.

The same register holds a flag that says the configuration memory has been loaded. Three standard requests depend on that memory: GET_DESCRIPTOR, SET_CONFIGURATION and SET_INTERFACE. If one of them arrives while the flag is clear, the block pulses an access-error output for one cycle and answers the request with STALL. All other standard requests are handled elsewhere, and the block reports "no verdict" for them. A latched outcome holds until the next SETUP packet replaces it.

Top module: `ep0_status_hs`

## Requirements
- R1: After reset the valid flag is 0, `hs_code` is 2'b00 (no verdict), `fw_pending` is 0, `acc_err` is 0 and `reg_rdata` is 0.
- R2: `reg_rdata` bit 0 returns the valid flag, which a write stores from `reg_wdata` bit 0. Every other read bit is 0, including the write-only command bits: bit 1 (done) and bit 2 (fail).
- R3: A SETUP with type 1 (class) or type 2 (vendor), or with type 0 (standard) and code 12 (SYNCH_FRAME), makes `hs_code` 2'b10 (NAK) and sets `fw_pending`. This takes effect in the cycle after `setup_vld`.
- R4: While a request is pending, a write with bit 1 = 1 and bit 2 = 0 makes `hs_code` 2'b01 (ACK) on the next cycle and clears `fw_pending`.
- R5: While a request is pending, a write with bit 1 = 1 and bit 2 = 1 makes `hs_code` 2'b11 (STALL) and clears `fw_pending`.
- R6: While a request is pending, a write with bit 1 = 0 leaves `hs_code` at NAK, whatever bit 2 holds.
- R7: A standard SETUP with code 6, 9 or 11 while the valid flag is 0 makes `acc_err` high for exactly the following cycle and sets `hs_code` to STALL. With the flag set, the same request gives no pulse and `hs_code` 2'b00.
- R8: Any other standard code, and any SETUP of type 3, gives `hs_code` 2'b00 with no pulse and no pending request.
- R9: A latched outcome holds until the next SETUP. Command writes made while no request is pending leave `hs_code` unchanged, and a new SETUP replaces any earlier outcome.
- R10: When a SETUP and a register write arrive in the same cycle, the SETUP decides the outcome, and its command bits are discarded. The classification uses the valid flag as it stood before that write, while the write still updates the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | REG_W | Write data: bit 0 valid flag, bit 1 done, bit 2 fail |
| reg_rdata | output | REG_W | Read data: valid flag in bit 0, rest zero |
| setup_vld | input | 1 | SETUP packet received this cycle |
| setup_type | input | 2 | Request type: 0 standard, 1 class, 2 vendor, 3 reserved |
| setup_code | input | CODE_W | Request code |
| hs_code | output | 2 | Status verdict: 00 none, 01 ACK, 10 NAK, 11 STALL |
| fw_pending | output | 1 | A firmware-handled request awaits its outcome |
| acc_err | output | 1 | One-cycle pulse: configuration memory request while invalid |

## Verification
The hardest situation to reach is a SETUP and a register write landing in the same cycle. In that case the SETUP must win, and the classification must use the valid flag from before the write. The bench produces this case directly: it drives both strobes in one cycle, once with a firmware request and once with a configuration-memory request, while the write flips the valid flag. Back-to-back SETUPs arriving during a pending request are also driven, to show that a new request replaces the old outcome.

// File: rtl/ep0_hs_pkg.sv
package ep0_hs_pkg;

  typedef enum logic [2:0] {
    RS_IDLE = 3'd0,
    RS_BUSY = 3'd1,
    RS_OK   = 3'd2,
    RS_FAIL = 3'd3,
    RS_DENY = 3'd4
  } res_t;

  typedef enum logic [1:0] {
    HS_NONE  = 2'b00,
    HS_ACK   = 2'b01,
    HS_NAK   = 2'b10,
    HS_STALL = 2'b11
  } hs_t;

  localparam logic [1:0] TYPE_STD    = 2'd0;
  localparam logic [1:0] TYPE_CLASS  = 2'd1;
  localparam logic [1:0] TYPE_VENDOR = 2'd2;

  localparam int CODE_GET_DESC  = 6;
  localparam int CODE_SET_CFG   = 9;
  localparam int CODE_SET_IF    = 11;
  localparam int CODE_SYNCH_FRM = 12;

  localparam int BIT_VALID = 0;
  localparam int BIT_DONE  = 1;
  localparam int BIT_FAIL  = 2;

  function automatic hs_t verdict_of(res_t r);
    case (r)
      RS_BUSY: verdict_of = HS_NAK;
      RS_OK:   verdict_of = HS_ACK;
      RS_FAIL: verdict_of = HS_STALL;
      RS_DENY: verdict_of = HS_STALL;
      default: verdict_of = HS_NONE;
    endcase
  endfunction

endpackage

// File: rtl/ep0_req_classify.sv
module ep0_req_classify
  import ep0_hs_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic [1:0]        req_type,
  input  logic [CODE_W-1:0] req_code,
  input  logic              cfg_valid,
  output logic              to_fw,
  output logic              to_deny
);
  logic is_std;
  logic uses_cfg;

  always_comb begin
    is_std   = (req_type == TYPE_STD);
    uses_cfg = is_std && ((req_code == CODE_W'(CODE_GET_DESC)) ||
                          (req_code == CODE_W'(CODE_SET_CFG))  ||
                          (req_code == CODE_W'(CODE_SET_IF)));
    to_fw    = (req_type == TYPE_CLASS) || (req_type == TYPE_VENDOR) ||
               (is_std && (req_code == CODE_W'(CODE_SYNCH_FRM)));
    to_deny  = uses_cfg && !cfg_valid;
  end
endmodule

// File: rtl/ep0_cfg_reg.sv
module ep0_cfg_reg
  import ep0_hs_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             wr_valid,
  output logic             cfg_valid,
  output logic [REG_W-1:0] rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg_valid <= 1'b0;
    else if (wr) cfg_valid <= wr_valid;
  end

  generate
    if (REG_W > 1) begin : g_pad
      assign rdata = {{(REG_W-1){1'b0}}, cfg_valid};
    end else begin : g_bare
      assign rdata = cfg_valid;
    end
  endgenerate
endmodule

// File: rtl/ep0_result_fsm.sv
module ep0_result_fsm
  import ep0_hs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic setup_vld,
  input  logic to_fw,
  input  logic to_deny,
  input  logic cmd_wr,
  input  logic cmd_done,
  input  logic cmd_fail,
  output res_t state,
  output logic deny_pulse
);
  res_t nxt;

  always_comb begin
    nxt = state;
    if (setup_vld) begin
      if (to_fw)        nxt = RS_BUSY;
      else if (to_deny) nxt = RS_DENY;
      else              nxt = RS_IDLE;
    end else if (cmd_wr && state == RS_BUSY && cmd_done) begin
      nxt = cmd_fail ? RS_FAIL : RS_OK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= RS_IDLE;
      deny_pulse <= 1'b0;
    end else begin
      state      <= nxt;
      deny_pulse <= setup_vld && !to_fw && to_deny;
    end
  end
endmodule

// File: rtl/ep0_status_hs.sv
module ep0_status_hs
  import ep0_hs_pkg::*;
#(
  parameter int REG_W  = 8,
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              setup_vld,
  input  logic [1:0]        setup_type,
  input  logic [CODE_W-1:0] setup_code,
  output logic [1:0]        hs_code,
  output logic              fw_pending,
  output logic              acc_err
);
  logic cfg_valid;
  logic route_fw;
  logic route_deny;
  logic wr_done;
  logic wr_fail;
  res_t res_q;
  logic unused_wbits;

  assign wr_done      = reg_wdata[BIT_DONE];
  assign wr_fail      = reg_wdata[BIT_FAIL];
  assign unused_wbits = ^reg_wdata;

  ep0_cfg_reg #(.REG_W(REG_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (reg_wr),
    .wr_valid  (reg_wdata[BIT_VALID]),
    .cfg_valid (cfg_valid),
    .rdata     (reg_rdata)
  );

  ep0_req_classify #(.CODE_W(CODE_W)) u_cls (
    .req_type  (setup_type),
    .req_code  (setup_code),
    .cfg_valid (cfg_valid),
    .to_fw     (route_fw),
    .to_deny   (route_deny)
  );

  ep0_result_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .setup_vld  (setup_vld),
    .to_fw      (route_fw),
    .to_deny    (route_deny),
    .cmd_wr     (reg_wr),
    .cmd_done   (wr_done),
    .cmd_fail   (wr_fail),
    .state      (res_q),
    .deny_pulse (acc_err)
  );

  assign hs_code    = verdict_of(res_q);
  assign fw_pending = (res_q == RS_BUSY);
endmodule

// File: rtl/ep0_status_hs_chk.sv
module ep0_status_hs_chk #(
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic             wr_done,
  input logic             wr_fail,
  input logic [REG_W-1:0] reg_rdata,
  input logic             setup_vld,
  input logic             route_fw,
  input logic [1:0]       hs_code,
  input logic             fw_pending,
  input logic             acc_err
);
  // R2
  rdata_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[REG_W-1:1] == '0);

  // R3
  fw_route_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setup_vld && route_fw |=> hs_code == 2'b10 && fw_pending);

  // R4
  done_ok_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fw_pending && reg_wr && wr_done && !wr_fail && !setup_vld |=> hs_code == 2'b01);

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fw_pending && !setup_vld && !(reg_wr && wr_done) |=> hs_code == 2'b10);

  // R7
  deny_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> hs_code == 2'b11 && !fw_pending);

  // R7
  deny_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_err) |-> $past(setup_vld));

  // R9
  outcome_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !setup_vld && !fw_pending |=> $stable(hs_code));
endmodule

bind ep0_status_hs ep0_status_hs_chk #(.REG_W(REG_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr     (reg_wr),
  .wr_done    (wr_done),
  .wr_fail    (wr_fail),
  .reg_rdata  (reg_rdata),
  .setup_vld  (setup_vld),
  .route_fw   (route_fw),
  .hs_code    (hs_code),
  .fw_pending (fw_pending),
  .acc_err    (acc_err)
);

// File: tb/test_ep0_status_hs.sv
module test_ep0_status_hs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       setup_vld = 1'b0;
  logic [1:0] setup_type = '0;
  logic [7:0] setup_code = '0;
  logic [1:0] hs_code;
  logic       fw_pending;
  logic       acc_err;

  int checks = 0;
  int errors = 0;
  string phase = "R1";
  bit done_flag = 0;

  // reference model: 0 idle,1 busy,2 ok,3 fail,4 deny
  int  m_st = 0;
  bit  m_valid = 0;
  bit  m_acc = 0;

  always #4 clk = ~clk;

  ep0_status_hs i_ep0_status_hs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .setup_vld(setup_vld), .setup_type(setup_type),
    .setup_code(setup_code), .hs_code(hs_code), .fw_pending(fw_pending),
    .acc_err(acc_err)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_hs(int st);
    if (st == 1) return 2;
    if (st == 2) return 1;
    if (st == 3 || st == 4) return 3;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_valid = 0; m_acc = 0;
    end else begin
      bit cfgreq, fw;
      m_acc = 0;
      if (setup_vld) begin
        fw = (setup_type == 1) || (setup_type == 2) ||
             (setup_type == 0 && setup_code == 12);
        cfgreq = (setup_type == 0) &&
                 (setup_code == 6 || setup_code == 9 || setup_code == 11);
        if (fw) m_st = 1;
        else if (cfgreq && !m_valid) begin m_st = 4; m_acc = 1; end
        else m_st = 0;
      end else if (reg_wr && m_st == 1 && reg_wdata[1]) begin
        m_st = reg_wdata[2] ? 3 : 2;
      end
      if (reg_wr) m_valid = reg_wdata[0];
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      check(phase, "model hs_code", hs_code, exp_hs(m_st));
      check(phase, "model fw_pending", fw_pending, m_st == 1);
      check(phase, "model acc_err", acc_err, m_acc);
      check(phase, "model rdata", reg_rdata, m_valid);
    end
  end

  task automatic idle();
    reg_wr = 0; setup_vld = 0;
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk); idle(); reg_wr = 1; reg_wdata = d;
    @(negedge clk); idle();
  endtask

  task automatic setup(logic [1:0] t, logic [7:0] c);
    @(negedge clk); idle(); setup_vld = 1; setup_type = t; setup_code = c;
    @(negedge clk); idle();
  endtask

  task automatic finish_run();
    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    phase = "R1";
    check("R1", "reset hs_code", hs_code, 0);
    check("R1", "reset rdata", reg_rdata, 0);
    check("R1", "reset fw_pending", fw_pending, 0);
    check("R1", "reset acc_err", acc_err, 0);
    rst_n = 1;
    @(negedge clk);

    phase = "R2";
    wr(8'hFF); check("R2", "rdata after ff", reg_rdata, 1);
    wr(8'h06); check("R2", "rdata after 06", reg_rdata, 0);

    phase = "R3";
    setup(2'd1, 8'h20); check("R3", "class nak", hs_code, 2);
    check("R3", "class pending", fw_pending, 1);
    phase = "R6";
    wr(8'h04); check("R6", "fail without done", hs_code, 2);
    wr(8'h00); check("R6", "no done", hs_code, 2);
    phase = "R4";
    wr(8'h02); check("R4", "ack", hs_code, 1);
    check("R4", "pending cleared", fw_pending, 0);
    phase = "R9";
    wr(8'h06); check("R9", "ignored write keeps ack", hs_code, 1);
    repeat (3) @(negedge clk);
    check("R9", "ack held", hs_code, 1);

    phase = "R5";
    setup(2'd2, 8'h01); check("R3", "vendor nak", hs_code, 2);
    wr(8'h06); check("R5", "stall", hs_code, 3);
    check("R5", "pending cleared", fw_pending, 0);

    phase = "R3";
    setup(2'd0, 8'd12); check("R3", "synch frame nak", hs_code, 2);
    phase = "R9";
    setup(2'd1, 8'h33); check("R9", "new setup while busy", hs_code, 2);
    wr(8'h02);
    setup(2'd0, 8'd5); check("R9", "new setup replaces ack", hs_code, 0);

    phase = "R7";
    wr(8'h00);
    @(negedge clk); setup_vld = 1; setup_type = 0; setup_code = 8'd6;
    @(negedge clk); idle();
    check("R7", "acc_err pulse", acc_err, 1);
    check("R7", "deny stall", hs_code, 3);
    @(negedge clk);
    check("R7", "acc_err one cycle", acc_err, 0);
    check("R7", "stall held", hs_code, 3);
    setup(2'd0, 8'd9);  check("R7", "set cfg denied", acc_err, 1);
    setup(2'd0, 8'd11); check("R7", "set if denied", hs_code, 3);
    wr(8'h01);
    setup(2'd0, 8'd9);  check("R7", "valid no pulse", acc_err, 0);
    check("R7", "valid no verdict", hs_code, 0);

    phase = "R8";
    setup(2'd0, 8'd5);  check("R8", "other std", hs_code, 0);
    setup(2'd3, 8'd12); check("R8", "reserved type", hs_code, 0);
    check("R8", "reserved no pending", fw_pending, 0);

    phase = "R10";
    @(negedge clk); setup_vld = 1; setup_type = 1; setup_code = 8'h10;
    reg_wr = 1; reg_wdata = 8'h02;
    @(negedge clk); idle();
    check("R10", "setup wins over cmd", hs_code, 2);
    check("R10", "flag updated by same write", reg_rdata, 0);
    @(negedge clk); setup_vld = 1; setup_type = 0; setup_code = 8'd6;
    reg_wr = 1; reg_wdata = 8'h01;
    @(negedge clk); idle();
    check("R10", "old flag used", acc_err, 1);
    check("R10", "flag now set", reg_rdata, 1);
    @(negedge clk); setup_vld = 1; setup_type = 0; setup_code = 8'd6;
    reg_wr = 1; reg_wdata = 8'h00;
    @(negedge clk); idle();
    check("R10", "old set flag allows", acc_err, 0);
    check("R10", "allowed no verdict", hs_code, 0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule